// File: doc/BRIEF.md
# Two-Way Coherent Data Cache Controller

This block is the controller of a small first-level data cache. It has two ways, and each set holds one line per way. Every line has an address tag, a two-bit coherence state (Modified, Exclusive, Shared or Invalid) and a full copy of its data in internal registers. Each set also has one replacement bit that names the way to evict next. A processor issues single-word loads and stores through a valid/ready request port. Each store carries its own flag that picks write-back or write-through handling. The controller answers each request with one response pulse.

Misses go out on a line-wide memory port that serves both refills and write-backs. A Modified victim is always written out before its replacement is fetched. A refill comes back with a flag that says whether another holder shares the line, and that flag decides whether the new line starts as Shared or Exclusive. An external coherence agent can snoop a line while the controller is idle, either to invalidate it or to demote it to Shared. When the snooped line is dirty, the controller writes it back to memory before it changes the line's state.

With the default parameters the cache has 128 sets of two 32-byte lines, which makes 4 KB per way and 8 KB in total. Addresses are 32 bits wide: bits [31:12] are the tag, bits [11:5] select the set and bits [4:0] give the byte within the line.

Top module: `l1d_mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid, `req_ready` is high, and neither `resp_valid` nor `mem_req_valid` is asserted. The first access to any line therefore misses, reports `resp_hit`=0, and issues one memory read (`mem_req_write`=0) at the line-aligned address.
- R2: A load returns the 32-bit word at address bits [4:2] of its line. The value reflects every earlier store to that word, whether the line stayed resident or was evicted and refetched.
- R3: A refill installs the line as Exclusive (`resp_state`=2'b10), or as Shared (2'b01) when `mem_shared` is high during the refill acknowledge. The state encoding is Invalid 2'b00, Shared 2'b01, Exclusive 2'b10, Modified 2'b11.
- R4: On a miss the victim is an Invalid way when the set has one. Otherwise the victim is the way named by the set's replacement bit. Every access that hits sets that bit to the other way, so the more recently used line survives.
- R5: A Modified victim is first written to memory (`mem_req_write`=1, at the victim's own line address, with its full contents). Only after that is the refill read issued. A miss whose victim is clean causes exactly one memory operation.
- R6: A store that hits with `req_wthru`=0 updates only the bytes selected by `req_be`, bit i enabling byte i. It causes no memory traffic and leaves the line Modified.
- R7: A store with `req_wthru`=1 writes the whole updated line to memory at its line address before it responds. The line then keeps its Exclusive or Shared state. A write-through store that misses refills the line first, which makes two memory operations.
- R8: A snoop with `snp_inval`=1 that hits a Modified line writes the line back first and then makes it Invalid. On a clean line it invalidates with no memory traffic. Either way, the next access to that line misses.
- R9: A snoop with `snp_inval`=0 that hits leaves the line Shared. A Modified line is written back first, and a clean line is demoted with no traffic. Either way, the next access hits.
- R10: A snoop whose address matches no valid line causes no memory traffic and changes no resident line.
- R11: `req_ready` is low from the cycle after a request is accepted until its response. `resp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wthru | input | 1 | Store uses write-through handling |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 32 | Load data (a store returns the word's prior value) |
| resp_hit | output | 1 | The first lookup for the request hit |
| resp_state | output | 2 | Coherence state of the line after the access |
| mem_req_valid | output | 1 | Memory operation pending |
| mem_req_write | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 256 | Line contents for a write |
| mem_ack | input | 1 | One-cycle completion of the pending memory operation |
| mem_rdata | input | 256 | Refill data, valid with `mem_ack` |
| mem_shared | input | 1 | Refilled line is also held elsewhere |
| snp_valid | input | 1 | Snoop present |
| snp_ready | output | 1 | Controller is idle and takes a snoop |
| snp_inval | input | 1 | 1 = invalidate, 0 = demote to Shared |
| snp_addr | input | 32 | Snooped address |

## Verification
The embedded properties assume three things about the neighbours. Memory raises `mem_ack` for one cycle, and only while a request is pending. Snoops arrive only when `snp_ready` is high. Requests are presented only when `req_ready` is high. The bench meets all three. Its memory model waits a fixed latency before it acknowledges and then drops the acknowledge on the following cycle. Its request and snoop tasks wait for the ready signal at a falling edge before they drive anything. Under those conditions the properties check the following: a memory request holds its address and data until it is acknowledged, responses are single pulses, a store in write-back mode always reports Modified, and a dirty eviction is followed directly by a refill read.

// File: rtl/l1d_pkg.sv
package l1d_pkg;

    // coherence encoding; the value is visible on resp_state
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_st_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LOOK,
        F_EVICT,
        F_FILL,
        F_WTHRU,
        F_SNPWB
    } fsm_e;

endpackage

// File: rtl/l1d_tag_match.sv
module l1d_tag_match
    import l1d_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][TAG_W-1:0] way_tag,
    input  line_st_e [1:0]        way_st,
    input  logic [TAG_W-1:0]      probe,
    output logic [1:0]            hit
);

    for (genvar g = 0; g < 2; g++) begin : g_way
        assign hit[g] = (way_st[g] != LS_INV) && (way_tag[g] == probe);
    end

    // a set never holds the same valid tag twice
    p_single_hit_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));

endmodule

// File: rtl/l1d_victim_pick.sv
module l1d_victim_pick
    import l1d_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  line_st_e [1:0] way_st,
    input  logic           lru,
    output logic           way
);

    logic [1:0] valid;

    always_comb begin
        valid[0] = (way_st[0] != LS_INV);
        valid[1] = (way_st[1] != LS_INV);
        if (!valid[0])      way = 1'b0;
        else if (!valid[1]) way = 1'b1;
        else                way = lru;
    end

    p_free_way_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (way_st[way] != LS_INV) |-> (way_st[!way] != LS_INV));

endmodule

// File: rtl/l1d_word_merge.sv
module l1d_word_merge #(
    parameter int LINE_W = 256,
    parameter int WORD_W = 32
) (
    input  logic [LINE_W-1:0]                  line,
    input  logic [WORD_W-1:0]                  word,
    input  logic [WORD_W/8-1:0]                be,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]   sel,
    output logic [WORD_W-1:0]                  rd_word,
    output logic [LINE_W-1:0]                  merged
);

    localparam int BYTES = WORD_W / 8;

    logic [WORD_W-1:0] mask;
    logic [LINE_W-1:0] mask_sh;
    logic [LINE_W-1:0] data_sh;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign mask[b*8 +: 8] = {8{be[b]}};
    end

    assign rd_word = line[sel*WORD_W +: WORD_W];
    assign mask_sh = {{(LINE_W-WORD_W){1'b0}}, mask} << (sel*WORD_W);
    assign data_sh = {{(LINE_W-WORD_W){1'b0}}, word & mask} << (sel*WORD_W);
    assign merged  = (line & ~mask_sh) | data_sh;

endmodule

// File: rtl/l1d_mesi_ctrl.sv
module l1d_mesi_ctrl
    import l1d_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_wthru,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [8*WORD_BYTES-1:0] req_wdata,
    input  logic [WORD_BYTES-1:0]   req_be,
    output logic                    resp_valid,
    output logic [8*WORD_BYTES-1:0] resp_rdata,
    output logic                    resp_hit,
    output logic [1:0]              resp_state,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [8*LINE_BYTES-1:0] mem_req_wdata,
    input  logic                    mem_ack,
    input  logic [8*LINE_BYTES-1:0] mem_rdata,
    input  logic                    mem_shared,
    input  logic                    snp_valid,
    output logic                    snp_ready,
    input  logic                    snp_inval,
    input  logic [ADDR_W-1:0]       snp_addr
);

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W  = 8 * LINE_BYTES;
    localparam int WORD_W  = 8 * WORD_BYTES;
    localparam int WSEL_W  = $clog2(LINE_BYTES / WORD_BYTES);
    localparam int WSEL_LO = $clog2(WORD_BYTES);
    localparam int ENT     = 2 * SETS;

    typedef struct packed {
        fsm_e                  fsm;
        logic [ADDR_W-1:0]     addr;
        logic [WORD_W-1:0]     wdata;
        logic [WORD_BYTES-1:0] be;
        logic                  wr;
        logic                  wt;
        logic                  snp_inv;
        logic                  way;
        logic                  missed;
        logic                  rsp_v;
        logic [WORD_W-1:0]     rsp_data;
        logic                  rsp_hit;
        line_st_e              rsp_st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // directory, data and replacement storage
    logic [TAG_W-1:0]  tag_q [ENT];
    line_st_e          st_q  [ENT];
    logic [LINE_W-1:0] dat_q [ENT];
    logic [SETS-1:0]   lru_q;

    // lookup datapath
    logic [ADDR_W-1:0]      lk_addr;
    logic [IDX_W-1:0]       lk_set;
    logic [TAG_W-1:0]       lk_tag;
    logic [1:0][TAG_W-1:0]  way_tag;
    line_st_e [1:0]         way_st;
    logic [1:0]             hit;
    logic                   hit_way, vic_way;
    logic [IDX_W:0]         cur_ent, vic_ent, pick_ent;
    logic [LINE_W-1:0]      cur_line, merged;
    logic [WORD_W-1:0]      rd_word;
    line_st_e               cur_st;

    // storage write controls
    logic              st_we, tag_we, dat_we, lru_we, lru_val;
    logic [IDX_W:0]    st_ent, dat_ent;
    line_st_e          st_val;
    logic [LINE_W-1:0] dat_val;

    // memory port drive
    logic              m_v, m_w;
    logic [ADDR_W-1:0] m_a;
    logic [LINE_W-1:0] m_d;

    assign lk_addr  = (ctl_q.fsm == F_IDLE) ? snp_addr : ctl_q.addr;
    assign lk_set   = lk_addr[OFF_W +: IDX_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign hit_way  = hit[1];
    assign cur_ent  = {hit_way, lk_set};
    assign vic_ent  = {ctl_q.way, lk_set};
    assign pick_ent = {vic_way, lk_set};
    assign cur_line = dat_q[cur_ent];
    assign cur_st   = st_q[cur_ent];

    for (genvar w = 0; w < 2; w++) begin : g_dir
        assign way_tag[w] = tag_q[{w[0], lk_set}];
        assign way_st[w]  = st_q[{w[0], lk_set}];
    end

    l1d_tag_match #(.TAG_W(TAG_W)) i_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .way_tag (way_tag),
        .way_st  (way_st),
        .probe   (lk_tag),
        .hit     (hit)
    );

    l1d_victim_pick i_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .way_st (way_st),
        .lru    (lru_q[lk_set]),
        .way    (vic_way)
    );

    l1d_word_merge #(.LINE_W(LINE_W), .WORD_W(WORD_W)) i_merge (
        .line    (cur_line),
        .word    (ctl_q.wdata),
        .be      (ctl_q.be),
        .sel     (ctl_q.addr[WSEL_LO +: WSEL_W]),
        .rd_word (rd_word),
        .merged  (merged)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        st_we   = 1'b0;
        tag_we  = 1'b0;
        dat_we  = 1'b0;
        lru_we  = 1'b0;
        lru_val = 1'b0;
        st_ent  = cur_ent;
        st_val  = LS_INV;
        dat_ent = cur_ent;
        dat_val = merged;
        m_v     = 1'b0;
        m_w     = 1'b0;
        m_a     = {ctl_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        m_d     = dat_q[vic_ent];

        unique case (ctl_q.fsm)
            F_IDLE: begin
                if (snp_valid) begin
                    if (|hit) begin
                        if (cur_st == LS_MOD) begin
                            ctl_d.fsm     = F_SNPWB;
                            ctl_d.addr    = snp_addr;
                            ctl_d.way     = hit_way;
                            ctl_d.snp_inv = snp_inval;
                        end else begin
                            st_we  = 1'b1;
                            st_val = snp_inval ? LS_INV : LS_SHR;
                        end
                    end
                end else if (req_valid) begin
                    ctl_d.fsm    = F_LOOK;
                    ctl_d.addr   = req_addr;
                    ctl_d.wdata  = req_wdata;
                    ctl_d.be     = req_be;
                    ctl_d.wr     = req_write;
                    ctl_d.wt     = req_wthru;
                    ctl_d.missed = 1'b0;
                end
            end
            F_LOOK: begin
                if (|hit) begin
                    lru_we         = 1'b1;
                    lru_val        = ~hit_way;
                    ctl_d.rsp_hit  = ~ctl_q.missed;
                    ctl_d.rsp_data = rd_word;
                    ctl_d.rsp_st   = cur_st;
                    ctl_d.way      = hit_way;
                    if (ctl_q.wr) begin
                        dat_we = 1'b1;
                        if (!ctl_q.wt) begin
                            st_we        = 1'b1;
                            st_val       = LS_MOD;
                            ctl_d.rsp_st = LS_MOD;
                        end
                    end
                    if (ctl_q.wr && ctl_q.wt) begin
                        ctl_d.fsm = F_WTHRU;
                    end else begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.fsm   = F_IDLE;
                    end
                end else begin
                    ctl_d.way    = vic_way;
                    ctl_d.missed = 1'b1;
                    ctl_d.fsm    = (st_q[pick_ent] == LS_MOD) ? F_EVICT : F_FILL;
                end
            end
            F_EVICT: begin
                m_v = 1'b1;
                m_w = 1'b1;
                m_a = {tag_q[vic_ent], lk_set, {OFF_W{1'b0}}};
                if (mem_ack) ctl_d.fsm = F_FILL;
            end
            F_FILL: begin
                m_v = 1'b1;
                if (mem_ack) begin
                    tag_we    = 1'b1;
                    st_we     = 1'b1;
                    st_ent    = vic_ent;
                    st_val    = mem_shared ? LS_SHR : LS_EXC;
                    dat_we    = 1'b1;
                    dat_ent   = vic_ent;
                    dat_val   = mem_rdata;
                    ctl_d.fsm = F_LOOK;
                end
            end
            F_WTHRU: begin
                m_v = 1'b1;
                m_w = 1'b1;
                if (mem_ack) begin
                    ctl_d.rsp_v = 1'b1;
                    ctl_d.fsm   = F_IDLE;
                end
            end
            F_SNPWB: begin
                m_v = 1'b1;
                m_w = 1'b1;
                if (mem_ack) begin
                    st_we     = 1'b1;
                    st_ent    = vic_ent;
                    st_val    = ctl_q.snp_inv ? LS_INV : LS_SHR;
                    ctl_d.fsm = F_IDLE;
                end
            end
            default: ctl_d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            lru_q <= '0;
            for (int i = 0; i < ENT; i++) st_q[i] <= LS_INV;
        end else begin
            ctl_q <= ctl_d;
            if (st_we)  st_q[st_ent]   <= st_val;
            if (lru_we) lru_q[lk_set]  <= lru_val;
        end
    end

    always_ff @(posedge clk) begin
        if (tag_we) tag_q[st_ent]  <= ctl_q.addr[ADDR_W-1 -: TAG_W];
        if (dat_we) dat_q[dat_ent] <= dat_val;
    end

    assign req_ready     = (ctl_q.fsm == F_IDLE) && !snp_valid;
    assign snp_ready     = (ctl_q.fsm == F_IDLE);
    assign resp_valid    = ctl_q.rsp_v;
    assign resp_rdata    = ctl_q.rsp_data;
    assign resp_hit      = ctl_q.rsp_hit;
    assign resp_state    = ctl_q.rsp_st;
    assign mem_req_valid = m_v;
    assign mem_req_write = m_w;
    assign mem_req_addr  = m_a;
    assign mem_req_wdata = m_d;

    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_addr)
                                         && $stable(mem_req_write) && $stable(mem_req_wdata)));

    p_fill_after_evict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.fsm == F_EVICT && mem_ack) |=> (mem_req_valid && !mem_req_write));

    p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_wb_store_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && ctl_q.wr && !ctl_q.wt) |-> (resp_state == LS_MOD));

endmodule

// File: tb/test_l1d_mesi_ctrl.sv
module test_l1d_mesi_ctrl;

    localparam int SETS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0, req_wthru = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic         req_ready, resp_valid, resp_hit;
    logic [31:0]  resp_rdata;
    logic [1:0]   resp_state;
    logic         mem_req_valid, mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [255:0] mem_req_wdata;
    logic         mem_ack = 1'b0, mem_shared = 1'b0;
    logic [255:0] mem_rdata = '0;
    logic         snp_valid = 1'b0, snp_inval = 1'b0, snp_ready;
    logic [31:0]  snp_addr = '0;

    always #4 clk = ~clk;

    l1d_mesi_ctrl #(.SETS(SETS)) i_l1d_mesi_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wthru(req_wthru), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_hit(resp_hit),
        .resp_state(resp_state),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_shared(mem_shared),
        .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_inval(snp_inval),
        .snp_addr(snp_addr)
    );

    int checks = 0, errors = 0;
    logic [255:0] mem_m [logic [31:0]];
    logic [31:0]  gold  [logic [31:0]];
    int           n_ops = 0;
    logic         log_wr   [256];
    logic [31:0]  log_addr [256];
    logic [255:0] log_data [256];

    logic [31:0] r_data;
    logic        r_hit;
    logic [1:0]  r_st;
    int          r_ops, op0;

    function automatic logic [31:0] adr(int t, int s, int w);
        return (32'(t) << 7) | (32'(s) << 5) | (32'(w) << 2);
    endfunction

    function automatic logic [31:0] init_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] a);
        return gold.exists(a) ? gold[a] : init_word(a);
    endfunction

    function automatic logic [255:0] exp_line(logic [31:0] la);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = exp_word(la + 32'(k*4));
        return l;
    endfunction

    function automatic logic [255:0] mem_line(logic [31:0] la);
        logic [255:0] l;
        if (mem_m.exists(la)) return mem_m[la];
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = init_word(la + 32'(k*4));
        return l;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // memory model: fixed latency, one-cycle acknowledge
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req_valid) begin
                if (wait_cnt == 2) begin
                    log_wr[n_ops % 256]   = mem_req_write;
                    log_addr[n_ops % 256] = mem_req_addr;
                    log_data[n_ops % 256] = mem_req_wdata;
                    if (mem_req_write) mem_m[mem_req_addr] = mem_req_wdata;
                    else               mem_rdata = mem_line(mem_req_addr);
                    n_ops++;
                    mem_ack  = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic access(input bit wr, input bit wt, input logic [31:0] a,
                          input logic [31:0] wd, input logic [3:0] be);
        logic [31:0] m;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write = wr; req_wthru = wt; req_addr = a; req_wdata = wd; req_be = be;
        req_valid = 1'b1;
        op0 = n_ops;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11 ready low while busy", 256'(req_ready), 256'(0));
        while (!resp_valid) @(negedge clk);
        r_data = resp_rdata; r_hit = resp_hit; r_st = resp_state; r_ops = n_ops - op0;
        if (!wr) begin
            chk(r_data == exp_word(a), "R2 load data", 256'(r_data), 256'(exp_word(a)));
        end else begin
            m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            gold[a] = (exp_word(a) & ~m) | (wd & m);
        end
        @(negedge clk);
        chk(!resp_valid, "R11 single response pulse", 256'(resp_valid), 256'(0));
    endtask

    task automatic snoop(input bit inv, input logic [31:0] a);
        @(negedge clk);
        while (!snp_ready) @(negedge clk);
        snp_inval = inv; snp_addr = a; snp_valid = 1'b1;
        op0 = n_ops;
        @(negedge clk);
        snp_valid = 1'b0;
        while (!snp_ready) @(negedge clk);
        r_ops = n_ops - op0;
    endtask

    task automatic chk_wr_op(input int idx, input logic [31:0] la, input string rq);
        chk(log_wr[idx % 256] == 1'b1, rq, 256'(log_wr[idx % 256]), 256'(1));
        chk(log_addr[idx % 256] == la, rq, 256'(log_addr[idx % 256]), 256'(la));
        chk(log_data[idx % 256] == exp_line(la), rq, log_data[idx % 256], exp_line(la));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 256'(req_ready), 256'(1));
        chk(resp_valid == 1'b0, "R1 no response after reset", 256'(resp_valid), 256'(0));
        chk(mem_req_valid == 1'b0, "R1 no memory request after reset", 256'(mem_req_valid), 256'(0));

        // R1/R2/R3: sweep every set and word, Exclusive fills
        mem_shared = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < 8; w++) begin
                access(1'b0, 1'b0, adr(1, s, w), '0, '0);
                if (w == 0) begin
                    chk(r_hit == 1'b0, "R1 first access misses", 256'(r_hit), 256'(0));
                    chk(r_ops == 1, "R1 one fill", 256'(r_ops), 256'(1));
                    chk(log_wr[op0 % 256] == 1'b0 && log_addr[op0 % 256] == adr(1, s, 0),
                        "R1 fill read at line address", 256'(log_addr[op0 % 256]), 256'(adr(1, s, 0)));
                end else begin
                    chk(r_hit == 1'b1 && r_ops == 0, "R2 resident hit", 256'(r_ops), 256'(0));
                end
                chk(r_st == 2'b10, "R3 exclusive fill", 256'(r_st), 256'(2'b10));
            end
        end

        // R3: shared fills
        mem_shared = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            access(1'b0, 1'b0, adr(2, s, 1), '0, '0);
            chk(r_hit == 1'b0 && r_st == 2'b01, "R3 shared fill", 256'(r_st), 256'(2'b01));
            access(1'b0, 1'b0, adr(2, s, 1), '0, '0);
            chk(r_hit == 1'b1 && r_st == 2'b01, "R3 shared hit", 256'(r_st), 256'(2'b01));
        end

        // R4: replacement order
        for (int s = 0; s < SETS; s++) begin
            access(1'b0, 1'b0, adr(1, s, 2), '0, '0);
            chk(r_hit == 1'b1, "R4 refresh hit", 256'(r_hit), 256'(1));
            access(1'b0, 1'b0, adr(3, s, 0), '0, '0);
            chk(r_ops == 1 && log_wr[op0 % 256] == 1'b0, "R4 clean victim one read", 256'(r_ops), 256'(1));
            access(1'b0, 1'b0, adr(1, s, 4), '0, '0);
            chk(r_hit == 1'b1, "R4 recently used line kept", 256'(r_hit), 256'(1));
            access(1'b0, 1'b0, adr(2, s, 1), '0, '0);
            chk(r_hit == 1'b0, "R4 older line was evicted", 256'(r_hit), 256'(0));
        end

        // R6: all byte-enable patterns in write-back mode
        mem_shared = 1'b0;
        for (int be = 0; be < 16; be++) begin
            access(1'b1, 1'b0, adr(1, 0, 3), 32'hC3A5_0000 ^ (32'(be) * 32'h0101_0111), 4'(be));
            chk(r_hit == 1'b1 && r_ops == 0, "R6 store hit without traffic", 256'(r_ops), 256'(0));
            chk(r_st == 2'b11, "R6 store leaves line modified", 256'(r_st), 256'(2'b11));
            access(1'b0, 1'b0, adr(1, 0, 3), '0, '0);
        end
        for (int s = 1; s < SETS; s++) access(1'b1, 1'b0, adr(1, s, 0), 32'h1234_0000 + 32'(s), 4'hF);

        // R5: dirty victim written back before refill
        for (int s = 0; s < SETS; s++) begin
            access(1'b0, 1'b0, adr(2, s, 1), '0, '0);
            access(1'b0, 1'b0, adr(4, s, 0), '0, '0);
            chk(r_ops == 2, "R5 two operations", 256'(r_ops), 256'(2));
            chk_wr_op(op0, adr(1, s, 0), "R5 write-back first");
            chk(log_wr[(op0 + 1) % 256] == 1'b0 && log_addr[(op0 + 1) % 256] == adr(4, s, 0),
                "R5 refill after write-back", 256'(log_addr[(op0 + 1) % 256]), 256'(adr(4, s, 0)));
            access(1'b0, 1'b0, adr(1, s, (s == 0) ? 3 : 0), '0, '0);
            chk(r_hit == 1'b0, "R5 written-back line refetched", 256'(r_hit), 256'(0));
        end

        // R7: write-through on exclusive, shared and missing lines
        access(1'b1, 1'b1, adr(1, 2, 5), 32'hDEAD_BEEF, 4'hF);
        chk(r_ops == 1 && r_st == 2'b10, "R7 write-through keeps exclusive", 256'(r_st), 256'(2'b10));
        chk_wr_op(op0, adr(1, 2, 0), "R7 write-through line");
        mem_shared = 1'b1;
        access(1'b0, 1'b0, adr(5, 3, 0), '0, '0);
        access(1'b1, 1'b1, adr(5, 3, 2), 32'h0BAD_F00D, 4'b0110);
        chk(r_ops == 1 && r_st == 2'b01, "R7 write-through keeps shared", 256'(r_st), 256'(2'b01));
        chk_wr_op(op0, adr(5, 3, 0), "R7 write-through shared line");
        mem_shared = 1'b0;
        access(1'b1, 1'b1, adr(6, 1, 7), 32'h7777_1111, 4'hF);
        chk(r_hit == 1'b0 && r_ops == 2 && r_st == 2'b10, "R7 write-through miss", 256'(r_ops), 256'(2));
        chk_wr_op(op0 + 1, adr(6, 1, 0), "R7 write-through after refill");

        // R8: invalidating snoops
        access(1'b1, 1'b0, adr(4, 0, 1), 32'hFACE_0001, 4'hF);
        snoop(1'b1, adr(4, 0, 6));
        chk(r_ops == 1, "R8 dirty invalidate writes back", 256'(r_ops), 256'(1));
        chk_wr_op(op0, adr(4, 0, 0), "R8 snoop write-back");
        access(1'b0, 1'b0, adr(4, 0, 1), '0, '0);
        chk(r_hit == 1'b0 && r_ops == 1, "R8 invalidated line misses", 256'(r_hit), 256'(0));
        snoop(1'b1, adr(1, 0, 0));
        chk(r_ops == 0, "R8 clean invalidate no traffic", 256'(r_ops), 256'(0));
        access(1'b0, 1'b0, adr(1, 0, 3), '0, '0);
        chk(r_hit == 1'b0, "R8 clean invalidated line misses", 256'(r_hit), 256'(0));

        // R9: demoting snoops
        access(1'b1, 1'b0, adr(6, 1, 0), 32'h5555_AAAA, 4'b1001);
        snoop(1'b0, adr(6, 1, 0));
        chk(r_ops == 1, "R9 dirty demote writes back", 256'(r_ops), 256'(1));
        chk_wr_op(op0, adr(6, 1, 0), "R9 snoop write-back");
        access(1'b0, 1'b0, adr(6, 1, 0), '0, '0);
        chk(r_hit == 1'b1 && r_st == 2'b01, "R9 demoted line shared", 256'(r_st), 256'(2'b01));
        snoop(1'b0, adr(1, 2, 5));
        chk(r_ops == 0, "R9 clean demote no traffic", 256'(r_ops), 256'(0));
        access(1'b0, 1'b0, adr(1, 2, 5), '0, '0);
        chk(r_hit == 1'b1 && r_st == 2'b01, "R9 clean demoted line shared", 256'(r_st), 256'(2'b01));

        // R10: snoops to absent lines
        snoop(1'b1, adr(9, 3, 0));
        chk(r_ops == 0, "R10 absent invalidate no traffic", 256'(r_ops), 256'(0));
        snoop(1'b0, adr(10, 3, 4));
        chk(r_ops == 0, "R10 absent demote no traffic", 256'(r_ops), 256'(0));
        access(1'b0, 1'b0, adr(5, 3, 2), '0, '0);
        chk(r_hit == 1'b1 && r_st == 2'b01, "R10 resident line unchanged", 256'(r_st), 256'(2'b01));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule